// File: doc/BRIEF.md
# Synchronous Memory-Card Responder

This block is the card side of a three-wire synchronous memory-card link. A host drives a reset line, a card clock and a shared data line; the block answers on the data line through an output-enable plus data pair, with the line pulled high whenever nobody drives it low. All three card-side inputs are assumed already synchronous to the system clock. Each card-clock or reset transition is detected by comparing a signal with its value one system cycle earlier.

The block holds a 256-byte main store, a 4-byte security store and 32 protection bits that guard the lowest 32 main addresses. A reset pulse that contains a clock pulse makes the card send a 4-byte answer word. A start condition and a stop condition frame a 24-bit command. The command either streams bytes back least significant bit first or starts an internal processing phase. During that phase the card holds the line low for a fixed number of clock pulses and then releases it.

A host model or a protocol analyser uses this block as a stand-in card. The card changes its output only on falling card-clock edges, so the host samples each bit while the card clock is high.

Top module: `card_responder`

## Requirements
- R1: After system reset (`rst_n` low at a clock edge) `io_oe` is 0 and the card waits for a start condition.
- R2: When `card_rst` falls after a `card_clk` rising edge seen while it was high, the card drives answer bit 0 at once. Answer bytes are `ATR_WORD[7:0]` first, then `[15:8]`, `[23:16]` and `[31:24]`. If no clock pulse occurred during the reset pulse, nothing is driven.
- R3: A start is `io_in` falling while `card_clk` stays high, and a stop is `io_in` rising while `card_clk` stays high. Between them, command bits are sampled on `card_clk` rising edges, least significant bit first: control byte, then address byte, then data byte. A stop before all 24 bits have arrived discards the command.
- R4: Control 0x30 streams main bytes from the given address through address 255, which is 256 minus the address bytes in all.
- R5: Control 0x31 streams the 4 security bytes, index 0 first. Control 0x34 streams 4 protection bytes, where bit i of byte k is the protection bit of address 8k+i.
- R6: Each output bit is presented on a `card_clk` falling edge. For reads, the first falling edge after the stop presents bit 0, and each later falling edge presents the next bit. The falling edge after the last bit releases `io_oe`, and the output never changes while `card_clk` is high.
- R7: Controls 0x38, 0x39, 0x3C and 0x33 start processing. The line is driven low from the first `card_clk` falling edge after the stop for `PROC_CLKS` (default 8) falling edges and is released on the next one.
- R8: Control 0x38 writes the data byte to main memory unless the address is below 32 and its protection bit is set.
- R9: Control 0x39 writes security byte `addr[1:0]`. Control 0x3C sets the protection bit of an address below 32 only when the data byte equals that main byte. Control 0x33 changes no storage.
- R10: While `card_rst` is high `io_oe` is 0, so raising it ends any read or processing phase.
- R11: Start and stop conditions are ignored while the card is sending answer or read data or is processing.
- R12: Any other control code drives nothing, changes no storage and leaves the line released until the next start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| card_rst | input | 1 | Card reset line from the host, high active |
| card_clk | input | 1 | Card clock from the host |
| io_in | input | 1 | Level of the shared data line |
| io_oe | output | 1 | Card drives the data line when 1 |
| io_out | output | 1 | Level the card drives when `io_oe` is 1 |

## Verification
A wrong phase shows up at the ports within one card-clock period. A missed stop decode leaves the line released where bit 0 of a read was due. A stray start during a read cuts the stream short, which shows on the next sampled bit. A corrupted write or protection bit is only visible when the location is read back, so the bench follows every write with full reads of all three stores. It also counts the pulses of each processing phase exactly, so an off-by-one in the pulse count shows up as soon as the line is released.

// File: rtl/card_pkg.sv
// Shared types for the memory-card responder.
// Assumes: byte-wide stores, command control codes fixed by the protocol.
package card_pkg;

    typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_OUT, PH_PROC} phase_t;
    typedef enum logic [1:0] {SRC_ATR, SRC_MAIN, SRC_SEC, SRC_PROT} src_t;

    localparam logic [7:0] OP_RD_MAIN = 8'h30;
    localparam logic [7:0] OP_RD_SEC  = 8'h31;
    localparam logic [7:0] OP_CMP     = 8'h33;
    localparam logic [7:0] OP_RD_PROT = 8'h34;
    localparam logic [7:0] OP_WR_MAIN = 8'h38;
    localparam logic [7:0] OP_WR_SEC  = 8'h39;
    localparam logic [7:0] OP_WR_PROT = 8'h3C;

endpackage

// File: rtl/card_line_events.sv
// Detects edges and start/stop conditions on the three card wires.
// Assumes: inputs are synchronous to clk; events are single-cycle pulses.
module card_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic card_clk,
    input  logic io_in,
    output logic rst_rise,
    output logic rst_fall,
    output logic clk_rise,
    output logic clk_fall,
    output logic start_seen,
    output logic stop_seen
);
    logic rst_q, clk_q, io_q;

    // Hold last-cycle wire levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b0;
            clk_q <= 1'b0;
            io_q  <= 1'b1;
        end else begin
            rst_q <= card_rst;
            clk_q <= card_clk;
            io_q  <= io_in;
        end
    end

    // Edge and condition decode against the held levels.
    always_comb begin
        rst_rise   = card_rst & ~rst_q;
        rst_fall   = ~card_rst & rst_q;
        clk_rise   = card_clk & ~clk_q;
        clk_fall   = ~card_clk & clk_q;
        start_seen = card_clk & clk_q & io_q & ~io_in;
        stop_seen  = card_clk & clk_q & ~io_q & io_in;
    end
endmodule

// File: rtl/card_cmd_shift.sv
// Collects a fixed number of command bits, first bit into position 0.
// Assumes: shift_en is a one-cycle pulse per bit; extra bits after full are dropped.
module card_cmd_shift #(
    parameter int BITS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] word,
    output logic            full
);
    localparam int CNT_W = $clog2(BITS + 1);
    logic [CNT_W-1:0] cnt;

    assign full = (cnt == CNT_W'(BITS));

    // Place each received bit at the next free position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt  <= '0;
            word <= '0;
        end else if (shift_en && !full) begin
            word[cnt] <= bit_in;
            cnt       <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/card_store.sv
// Main, security and protection storage plus the answer word, with one
// byte read port selected by source and index.
// Assumes: PROT_BITS <= 2**ADDR_W and PROT_BITS is a multiple of 8.
module card_store
    import card_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SEC_BYTES = 4,
    parameter int PROT_BITS = 32,
    parameter int ATR_BYTES = 4,
    parameter int MAIN_MUL  = 37,
    parameter int MAIN_ADD  = 27,
    parameter logic [8*SEC_BYTES-1:0] SEC_INIT  = 32'h0081_C3FF,
    parameter logic [PROT_BITS-1:0]   PROT_INIT = 32'h0000_000F,
    parameter logic [8*ATR_BYTES-1:0] ATR_WORD  = 32'h5C17_E4A2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_main,
    input  logic              wr_sec,
    input  logic              set_prot,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  src_t              rd_src,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [7:0]        rd_byte,
    output logic [7:0]        main_at_wr,
    output logic              prot_at_wr
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PROT_BYTES = PROT_BITS / 8;
    localparam int SEC_W      = $clog2(SEC_BYTES);
    localparam int PB_W       = $clog2(PROT_BYTES);
    localparam int PI_W       = $clog2(PROT_BITS);
    localparam int AT_W       = $clog2(ATR_BYTES);

    logic [7:0]           main_mem [DEPTH];
    logic [7:0]           sec_mem  [SEC_BYTES];
    logic [PROT_BITS-1:0] prot_q;
    logic [7:0]           prot_b   [PROT_BYTES];
    logic [7:0]           atr_b    [ATR_BYTES];
    logic                 in_prot_range;

    // Main store: reset to an arithmetic pattern, written by update command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                main_mem[i] <= 8'((i * MAIN_MUL + MAIN_ADD) % 256);
        end else if (wr_main) begin
            main_mem[wr_addr] <= wr_data;
        end
    end

    // Security store and protection bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEC_BYTES; i++)
                sec_mem[i] <= SEC_INIT[i*8 +: 8];
            prot_q <= PROT_INIT;
        end else begin
            if (wr_sec)
                sec_mem[wr_addr[SEC_W-1:0]] <= wr_data;
            if (set_prot)
                prot_q[wr_addr[PI_W-1:0]] <= 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < PROT_BYTES; g++) begin : g_prot_bytes
            assign prot_b[g] = prot_q[g*8 +: 8];
        end
        for (g = 0; g < ATR_BYTES; g++) begin : g_atr_bytes
            assign atr_b[g] = ATR_WORD[g*8 +: 8];
        end
    endgenerate

    // Lookups at the write address for protection and compare decisions.
    always_comb begin
        in_prot_range = (32'(wr_addr) < 32'(PROT_BITS));
        prot_at_wr    = in_prot_range & prot_q[wr_addr[PI_W-1:0]];
        main_at_wr    = main_mem[wr_addr];
    end

    // Read port multiplexer.
    always_comb begin
        case (rd_src)
            SRC_ATR:  rd_byte = atr_b[rd_idx[AT_W-1:0]];
            SRC_MAIN: rd_byte = main_mem[rd_idx];
            SRC_SEC:  rd_byte = sec_mem[rd_idx[SEC_W-1:0]];
            default:  rd_byte = prot_b[rd_idx[PB_W-1:0]];
        endcase
    end
endmodule

// File: rtl/card_responder.sv
// Card-side responder: answer-to-reset, command framing, read streaming
// and timed processing on a three-wire synchronous link.
// Assumes: card wires are synchronous to clk and stable for several cycles
// per level; the data line is pulled high when io_oe is 0.
module card_responder
    import card_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SEC_BYTES = 4,
    parameter int PROT_BITS = 32,
    parameter int ATR_BYTES = 4,
    parameter int PROC_CLKS = 8,
    parameter int MAIN_MUL  = 37,
    parameter int MAIN_ADD  = 27,
    parameter logic [8*SEC_BYTES-1:0] SEC_INIT  = 32'h0081_C3FF,
    parameter logic [PROT_BITS-1:0]   PROT_INIT = 32'h0000_000F,
    parameter logic [8*ATR_BYTES-1:0] ATR_WORD  = 32'h5C17_E4A2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic card_clk,
    input  logic io_in,
    output logic io_oe,
    output logic io_out
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PROT_BYTES = PROT_BITS / 8;
    localparam int CMD_BITS   = 24;
    localparam int PC_W       = $clog2(PROC_CLKS + 1);

    logic rst_rise, rst_fall, clk_rise, clk_fall, start_seen, stop_seen;
    logic [CMD_BITS-1:0] cmd_word;
    logic                cmd_full;
    logic [7:0]          c_ctrl, c_addr8, c_data;
    logic [ADDR_W-1:0]   c_addr;

    phase_t            phase;
    src_t              src;
    logic [ADDR_W-1:0] byte_ptr;
    logic [ADDR_W:0]   remain;
    logic [2:0]        bit_ptr;
    logic              primed, oe_q, rst_clk_seen;
    logic [PC_W-1:0]   proc_cnt;

    logic decode_now, shift_clear, shift_en;
    logic wr_main, wr_sec, set_prot, prot_at_wr;
    logic [7:0] rd_byte, main_at_wr;

    card_line_events u_ev (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_clk(card_clk),
        .io_in(io_in), .rst_rise(rst_rise), .rst_fall(rst_fall),
        .clk_rise(clk_rise), .clk_fall(clk_fall),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );

    card_cmd_shift #(.BITS(CMD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(shift_clear), .shift_en(shift_en),
        .bit_in(io_in), .word(cmd_word), .full(cmd_full)
    );

    card_store #(
        .ADDR_W(ADDR_W), .SEC_BYTES(SEC_BYTES), .PROT_BITS(PROT_BITS),
        .ATR_BYTES(ATR_BYTES), .MAIN_MUL(MAIN_MUL), .MAIN_ADD(MAIN_ADD),
        .SEC_INIT(SEC_INIT), .PROT_INIT(PROT_INIT), .ATR_WORD(ATR_WORD)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_main(wr_main), .wr_sec(wr_sec),
        .set_prot(set_prot), .wr_addr(c_addr), .wr_data(c_data),
        .rd_src(src), .rd_idx(byte_ptr), .rd_byte(rd_byte),
        .main_at_wr(main_at_wr), .prot_at_wr(prot_at_wr)
    );

    // Command field split and store-side write decisions at the stop.
    always_comb begin
        c_ctrl      = cmd_word[7:0];
        c_addr8     = cmd_word[15:8];
        c_data      = cmd_word[23:16];
        c_addr      = c_addr8[ADDR_W-1:0];
        decode_now  = !card_rst && phase == PH_CMD && !start_seen && stop_seen && cmd_full;
        shift_clear = rst_rise || (!card_rst && start_seen &&
                      (phase == PH_IDLE || phase == PH_CMD));
        shift_en    = !card_rst && phase == PH_CMD && clk_rise;
        wr_main     = decode_now && c_ctrl == OP_WR_MAIN && !prot_at_wr;
        wr_sec      = decode_now && c_ctrl == OP_WR_SEC;
        set_prot    = decode_now && c_ctrl == OP_WR_PROT &&
                      32'(c_addr) < 32'(PROT_BITS) && c_data == main_at_wr;
    end

    // Card sequencer: reset handling, framing, streaming and processing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            src          <= SRC_ATR;
            byte_ptr     <= '0;
            remain       <= '0;
            bit_ptr      <= '0;
            primed       <= 1'b0;
            oe_q         <= 1'b0;
            rst_clk_seen <= 1'b0;
            proc_cnt     <= '0;
        end else if (rst_rise) begin
            phase        <= PH_IDLE;
            oe_q         <= 1'b0;
            rst_clk_seen <= 1'b0;
        end else if (card_rst) begin
            if (clk_rise)
                rst_clk_seen <= 1'b1;
        end else if (rst_fall) begin
            rst_clk_seen <= 1'b0;
            if (rst_clk_seen) begin
                phase    <= PH_OUT;
                src      <= SRC_ATR;
                byte_ptr <= '0;
                remain   <= (ADDR_W+1)'(ATR_BYTES);
                bit_ptr  <= '0;
                primed   <= 1'b1;
                oe_q     <= 1'b1;
            end else begin
                phase <= PH_IDLE;
            end
        end else begin
            case (phase)
                PH_IDLE: if (start_seen) phase <= PH_CMD;
                PH_CMD: begin
                    if (start_seen) begin
                        phase <= PH_CMD;
                    end else if (stop_seen && !cmd_full) begin
                        phase <= PH_IDLE;
                    end else if (decode_now) begin
                        bit_ptr  <= '0;
                        primed   <= 1'b0;
                        proc_cnt <= '0;
                        byte_ptr <= '0;
                        case (c_ctrl)
                            OP_RD_MAIN: begin
                                phase    <= PH_OUT;
                                src      <= SRC_MAIN;
                                byte_ptr <= c_addr;
                                remain   <= (ADDR_W+1)'(DEPTH) - {1'b0, c_addr};
                            end
                            OP_RD_SEC: begin
                                phase  <= PH_OUT;
                                src    <= SRC_SEC;
                                remain <= (ADDR_W+1)'(SEC_BYTES);
                            end
                            OP_RD_PROT: begin
                                phase  <= PH_OUT;
                                src    <= SRC_PROT;
                                remain <= (ADDR_W+1)'(PROT_BYTES);
                            end
                            OP_WR_MAIN, OP_WR_SEC, OP_WR_PROT, OP_CMP:
                                phase <= PH_PROC;
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
                PH_OUT: if (clk_fall) begin
                    if (!primed) begin
                        primed <= 1'b1;
                        oe_q   <= 1'b1;
                    end else if (bit_ptr == 3'd7) begin
                        bit_ptr <= '0;
                        if (remain == (ADDR_W+1)'(1)) begin
                            oe_q  <= 1'b0;
                            phase <= PH_IDLE;
                        end else begin
                            remain   <= remain - 1'b1;
                            byte_ptr <= byte_ptr + 1'b1;
                        end
                    end else begin
                        bit_ptr <= bit_ptr + 1'b1;
                    end
                end
                default: if (clk_fall) begin
                    if (proc_cnt == PC_W'(PROC_CLKS)) begin
                        oe_q  <= 1'b0;
                        phase <= PH_IDLE;
                    end else begin
                        proc_cnt <= proc_cnt + 1'b1;
                        oe_q     <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Output: data bit when streaming, low level while processing.
    always_comb begin
        io_oe  = oe_q;
        io_out = (phase == PH_PROC) ? 1'b0 : rd_byte[bit_ptr];
    end
endmodule

// File: rtl/card_responder_chk.sv
// Port-level properties of the card responder, attached by bind.
// Assumes: same clock and synchronous reset as the responder.
module card_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic card_rst,
    input logic card_clk,
    input logic io_oe,
    input logic io_out
);
    logic clk_d, rst_d, any_fall;

    // Own copy of previous wire levels for edge reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b0;
            rst_d <= 1'b0;
        end else begin
            clk_d <= card_clk;
            rst_d <= card_rst;
        end
    end

    assign any_fall = (clk_d & ~card_clk) | (rst_d & ~card_rst);

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !io_oe);

    p_drive_starts_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_oe) |-> $past(any_fall));

    p_steady_while_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clk && $past(card_clk) && io_oe && $past(io_oe)) |-> $stable(io_out));

    p_quiet_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> !io_oe);
endmodule

bind card_responder card_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_clk(card_clk),
    .io_oe(io_oe), .io_out(io_out)
);

// File: tb/sim_card_responder.sv
// Bench for card_responder: host model with open-drain line, arithmetic
// reference stores, sweeps over every command and full-store read-backs.
module sim_card_responder;
    localparam int PROC_CLKS = 8;
    localparam logic [31:0] ATR_W = 32'h5C17_E4A2;
    localparam logic [31:0] SEC_I = 32'h0081_C3FF;
    localparam logic [31:0] PRO_I = 32'h0000_000F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 1'b0;
    logic card_clk = 1'b0;
    logic host_io = 1'b1;
    logic io_oe, io_out, io_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  m_main [256];
    logic [7:0]  m_sec  [4];
    logic [31:0] m_prot;

    always #2 clk = ~clk;

    assign io_line = (io_oe ? io_out : 1'b1) & host_io;

    card_responder u0 (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_clk(card_clk),
        .io_in(io_line), .io_oe(io_oe), .io_out(io_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(output logic b);
        card_clk = 1'b1; wait_h();
        b = io_line;
        card_clk = 1'b0; wait_h();
    endtask

    // Clock pulse with a host start/stop glitch while the clock is high.
    task automatic pulse_glitch(output logic b);
        card_clk = 1'b1; wait_h();
        b = io_line;
        host_io = 1'b0; wait_h();
        host_io = 1'b1; wait_h();
        card_clk = 1'b0; wait_h();
    endtask

    task automatic read_byte(input bit glitch, output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin
            if (glitch) pulse_glitch(b); else pulse(b);
            v[i] = b;
        end
    endtask

    task automatic card_reset(input bit with_clk);
        card_rst = 1'b1; wait_h();
        if (with_clk) begin
            card_clk = 1'b1; wait_h();
            card_clk = 1'b0; wait_h();
        end
        card_rst = 1'b0; wait_h();
    endtask

    task automatic send_bits(input logic [23:0] w, input int nbits);
        host_io = 1'b1; card_clk = 1'b1; wait_h();
        host_io = 1'b0; wait_h();
        card_clk = 1'b0; wait_h();
        for (int i = 0; i < nbits; i++) begin
            host_io = w[i]; wait_h();
            card_clk = 1'b1; wait_h();
            card_clk = 1'b0; wait_h();
        end
        host_io = 1'b0; wait_h();
        card_clk = 1'b1; wait_h();
        host_io = 1'b1; wait_h();
        card_clk = 1'b0; wait_h();
    endtask

    task automatic send_cmd(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d);
        send_bits({d, a, c}, 24);
    endtask

    task automatic proc_len(output int n);
        logic b;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            pulse(b);
            if (b) break;
            n++;
        end
    endtask

    task automatic read_main_from(input int a, input string tag);
        logic [7:0] v;
        send_cmd(8'h30, 8'(a), 8'h00);
        for (int i = a; i < 256; i++) begin
            read_byte(1'b0, v);
            chk(tag, int'(v), int'(m_main[i]));
        end
        chk({tag, " release"}, int'(io_oe), 0);
    endtask

    task automatic read_sec(input string tag);
        logic [7:0] v;
        send_cmd(8'h31, 8'h00, 8'h00);
        for (int i = 0; i < 4; i++) begin
            read_byte(1'b0, v);
            chk(tag, int'(v), int'(m_sec[i]));
        end
        chk({tag, " release"}, int'(io_oe), 0);
    endtask

    task automatic read_prot(input string tag);
        logic [7:0] v;
        send_cmd(8'h34, 8'h00, 8'h00);
        for (int i = 0; i < 4; i++) begin
            read_byte(1'b0, v);
            chk(tag, int'(v), int'(m_prot[i*8 +: 8]));
        end
        chk({tag, " release"}, int'(io_oe), 0);
    endtask

    task automatic do_proc(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d);
        int n;
        send_cmd(c, a, d);
        proc_len(n);
        chk("R7 processing low pulses", n, PROC_CLKS);
        chk("R7 released after processing", int'(io_oe), 0);
    endtask

    initial begin : main_seq
        logic [7:0] v;
        logic b;
        int lows;
        for (int i = 0; i < 256; i++) m_main[i] = 8'((i * 37 + 27) % 256);
        for (int i = 0; i < 4; i++) m_sec[i] = SEC_I[i*8 +: 8];
        m_prot = PRO_I;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_h();
        chk("R1 idle after reset", int'(io_oe), 0);

        card_reset(1'b0);
        chk("R2 no answer without clock pulse", int'(io_oe), 0);

        card_reset(1'b1);
        chk("R2 answer drives at once", int'(io_oe), 1);
        for (int k = 0; k < 4; k++) begin
            read_byte(1'b0, v);
            chk("R2 answer byte", int'(v), int'(ATR_W[k*8 +: 8]));
        end
        chk("R2 R6 answer released", int'(io_oe), 0);

        // Security read with start/stop glitches on byte 0 (all ones).
        send_cmd(8'h31, 8'h00, 8'h00);
        read_byte(1'b1, v);
        chk("R11 glitched byte", int'(v), int'(m_sec[0]));
        for (int i = 1; i < 4; i++) begin
            read_byte(1'b0, v);
            chk("R11 R5 stream continues", int'(v), int'(m_sec[i]));
        end
        chk("R6 release after security read", int'(io_oe), 0);

        read_prot("R5 protection read");
        read_main_from(240, "R4 main read tail");
        read_main_from(255, "R4 main read last");
        read_main_from(0, "R4 R3 main read full");

        do_proc(8'h38, 8'd40, 8'h5A);
        m_main[40] = 8'h5A;
        do_proc(8'h38, 8'd2, 8'h77);
        do_proc(8'h39, 8'd1, 8'h3C);
        m_sec[1] = 8'h3C;
        do_proc(8'h3C, 8'd6, m_main[6] ^ 8'h01);
        do_proc(8'h3C, 8'd6, m_main[6]);
        m_prot[6] = 1'b1;
        do_proc(8'h38, 8'd6, 8'h00);
        do_proc(8'h33, 8'd0, 8'h00);

        send_cmd(8'h3F, 8'd9, 8'hEE);
        lows = 0;
        for (int i = 0; i < 16; i++) begin
            pulse(b);
            if (!b || io_oe) lows++;
        end
        chk("R12 unknown control drives nothing", lows, 0);

        send_bits(24'h000031, 8);
        lows = 0;
        for (int i = 0; i < 16; i++) begin
            pulse(b);
            if (!b || io_oe) lows++;
        end
        chk("R3 short command discarded", lows, 0);

        read_main_from(0, "R8 R12 main after writes");
        read_sec("R9 security after writes");
        read_prot("R9 protection after writes");

        send_cmd(8'h30, 8'h00, 8'h00);
        read_byte(1'b0, v);
        chk("R10 read before abort", int'(v), int'(m_main[0]));
        card_rst = 1'b1; wait_h();
        chk("R10 reset ends read", int'(io_oe), 0);
        card_rst = 1'b0; wait_h();
        pulse(b);
        chk("R10 stays released", int'(b), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule